// File: doc/BRIEF.md
# ECC Memory Path with Scrubbing

This block sits between a host request port and a 64-bit memory array. Every stored word carries eight check bits: a seven-bit Hamming code plus one overall parity bit (a 72/64 SEC-DED code). Full-word writes go straight to memory with fresh check bits. When error checking is on, a write that enables only some bytes becomes a read, a byte merge and a full write-back. Reads decode the stored word. Depending on the integrity mode, they return corrected or raw data.

A two-bit integrity mode is sampled when a request is accepted. 00 turns protection off. 01 detects errors without correcting them. 10 corrects single-bit errors. 11 also writes the corrected word back to the same location on its own. Every detected error produces a one-cycle event carrying the word address and a single/multi-bit flag, which a separate error logger consumes. The memory answers a read in the cycle after it is issued. A write lands at the clock edge at which it is issued.

Top module: `ecc_mem_path`

## Requirements
- R1: After reset, req_ready is high, and resp_valid, err_valid and mem_en are low.
- R2: A full write (all eight byte enables) is accepted without lowering req_ready. Memory bits [63:0] hold the data and bits [71:64] the check byte. In modes 01 to 11 the check byte makes the word read back error-free. In mode 00 the check byte is written as zero.
- R3: In modes 01 to 11, a write with some byte enables low holds req_ready low for two cycles: one for the old-word read and one for the merged full write. In mode 00 it is a single byte-enabled memory write with req_ready kept high. Enabled bytes take the new data and the other bytes keep the old data.
- R4: A read raises resp_valid in the cycle after it is accepted, and req_ready is low in that cycle.
- R5: In modes 10 and 11, flipping any one of the 72 stored bits still returns the original data, and one event is raised with err_multi low.
- R6: In modes 01 to 11, flipping two stored bits returns the stored data uncorrected, raises one event with err_multi high, and triggers no write-back.
- R7: In mode 01, a single-bit error returns the raw stored data, raises a single-bit event, and leaves memory untouched.
- R8: In mode 00, reads return raw stored data and never raise an event.
- R9: In mode 11, a single-bit error on a read writes the corrected word back one cycle after the response. This restores the memory word and holds req_ready low for one extra cycle. Mode 10 leaves the corrupted word in memory.
- R10: Error events last exactly one cycle and carry the word address of the access.
- R11: An error found during the old-word read of a partial write raises an event. In modes 10 and 11 the unselected bytes are taken from the corrected old word, and in mode 01 from the raw old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| integ_mode | input | 2 | Integrity mode, sampled on request acceptance |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 8 | Byte enables for writes |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Read data valid |
| resp_data | output | 64 | Read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | 8 | Data byte enables (check byte is written on every write) |
| mem_wdata | output | 72 | Check byte [71:64] and data [63:0] |
| mem_rdata | input | 72 | Stored word, valid the cycle after a read |
| err_valid | output | 1 | One-cycle error event |
| err_multi | output | 1 | Event is uncorrectable (multi-bit) |
| err_addr | output | ADDR_W | Word address of the event |

## Verification
Stored-bit corruption cannot be produced through the host port, because every write produces consistent check bits. The bench's memory model therefore has a side channel that XORs a mask into a stored word between accesses. The sweep uses it to flip each of the 72 stored bits one at a time, and a rotating pair of bits, in every checking mode. After each corrupted read it checks both the returned data and the memory word itself, which shows whether scrubbing restored the word or left it alone. The same injection comes before partial writes, so that the merge path sees a corrupted old word.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
    localparam int DATA_W   = 64;
    localparam int HAM_W    = 7;
    localparam int CHK_W    = HAM_W + 1;
    localparam int WORD_W   = DATA_W + CHK_W;
    localparam int BE_W     = DATA_W / 8;
    localparam int LAST_POS = DATA_W + HAM_W;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_DETECT  = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_SCRUB   = 2'b11
    } integ_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_MERGE = 3'd2,
        ST_FILL  = 3'd3,
        ST_SCRUB = 3'd4
    } path_st_e;

    // Data bits occupy the non-power-of-two code positions 3..71 in order;
    // the Hamming bits are the XOR of the positions of all set data bits.
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] acc;
        int idx;
        acc = '0;
        idx = 0;
        for (int pos = 1; pos <= LAST_POS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[idx]) acc = acc ^ pos[HAM_W-1:0];
                idx++;
            end
        end
        return acc;
    endfunction
endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
    import ecc_mem_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic [HAM_W-1:0] ham;

    always_comb begin
        ham   = ham_bits(data_i);
        chk_o = {^{data_i, ham}, ham};
    end
endmodule

// File: rtl/ecc_check.sv
module ecc_check
    import ecc_mem_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              multi_o
);
    logic [DATA_W-1:0] raw;
    logic [HAM_W-1:0]  syn;
    logic              odd;
    int                idx;

    always_comb begin
        raw      = word_i[DATA_W-1:0];
        syn      = ham_bits(raw) ^ word_i[DATA_W +: HAM_W];
        odd      = ^word_i;
        single_o = odd && (syn <= HAM_W'(LAST_POS));
        multi_o  = (!odd && (syn != '0)) || (odd && (syn > HAM_W'(LAST_POS)));
        data_o   = raw;
        idx      = 0;
        for (int pos = 1; pos <= LAST_POS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (odd && (syn == pos[HAM_W-1:0])) data_o[idx] = ~raw[idx];
                idx++;
            end
        end
    end
endmodule

// File: rtl/ecc_mem_path.sv
module ecc_mem_path
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        integ_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              err_valid,
    output logic              err_multi,
    output logic [ADDR_W-1:0] err_addr
);
    localparam logic [BE_W-1:0] BE_ALL = '1;

    typedef struct packed {
        path_st_e          st;
        integ_mode_e       mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic [DATA_W-1:0] enc_data_d;
    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] fix_data;
    logic              dec_single, dec_multi;
    logic              corrects_d;
    logic [DATA_W-1:0] old_data_d, merged_d;
    integ_mode_e       mode_in;

    ecc_encode u_enc (.data_i(enc_data_d), .chk_o(enc_chk));

    ecc_check u_chk (
        .word_i  (mem_rdata),
        .data_o  (fix_data),
        .single_o(dec_single),
        .multi_o (dec_multi)
    );

    always_comb begin
        ctl_d      = ctl_q;
        mode_in    = integ_mode_e'(integ_mode);
        corrects_d = (ctl_q.mode == MODE_CORRECT) || (ctl_q.mode == MODE_SCRUB);
        old_data_d = corrects_d ? fix_data : mem_rdata[DATA_W-1:0];
        for (int b = 0; b < BE_W; b++) begin
            merged_d[8*b +: 8] = ctl_q.be[b] ? ctl_q.data[8*b +: 8] : old_data_d[8*b +: 8];
        end
        enc_data_d = (ctl_q.st == ST_IDLE) ? req_wdata : ctl_q.data;

        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_data  = old_data_d;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = ctl_q.addr;
        mem_be     = BE_ALL;
        mem_wdata  = {enc_chk, enc_data_d};
        err_valid  = 1'b0;
        err_multi  = dec_multi;
        err_addr   = ctl_q.addr;

        case (ctl_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_addr  = req_addr;
                if (req_valid) begin
                    mem_en     = 1'b1;
                    ctl_d.mode = mode_in;
                    ctl_d.addr = req_addr;
                    ctl_d.data = req_wdata;
                    ctl_d.be   = req_be;
                    if (!req_write) begin
                        ctl_d.st = ST_READ;
                    end else if (mode_in == MODE_OFF) begin
                        mem_we    = 1'b1;
                        mem_be    = req_be;
                        mem_wdata = {{CHK_W{1'b0}}, req_wdata};
                    end else if (req_be == BE_ALL) begin
                        mem_we = 1'b1;
                    end else begin
                        ctl_d.st = ST_MERGE;
                    end
                end
            end
            ST_READ: begin
                resp_valid = 1'b1;
                err_valid  = (ctl_q.mode != MODE_OFF) && (dec_single || dec_multi);
                ctl_d.data = fix_data;
                ctl_d.st   = ((ctl_q.mode == MODE_SCRUB) && dec_single) ? ST_SCRUB : ST_IDLE;
            end
            ST_MERGE: begin
                err_valid  = (ctl_q.mode != MODE_OFF) && (dec_single || dec_multi);
                ctl_d.data = merged_d;
                ctl_d.st   = ST_FILL;
            end
            ST_FILL, ST_SCRUB: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready && !req_write));

    assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && integ_mode == 2'b00) |=> (resp_valid && !err_valid));

    assert_rmw_sequence_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_be != BE_ALL && integ_mode != 2'b00)
        |=> (!req_ready && !mem_en) ##1 (!req_ready && mem_en && mem_we && mem_be == BE_ALL));

    assert_scrub_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && err_valid && !err_multi && ctl_q.mode == MODE_SCRUB)
        |=> (mem_en && mem_we && mem_addr == $past(err_addr)));

    assert_multi_no_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && err_valid && err_multi) |=> !mem_en);
endmodule

// File: tb/ecc_mem_path_tb.sv
module ecc_mem_path_tb_top;
    import ecc_mem_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int DEPTH      = 1 << AW;

    logic              clk, rst_n;
    logic [1:0]        integ_mode;
    logic              req_valid, req_ready, req_write;
    logic [AW-1:0]     req_addr;
    logic [7:0]        req_be;
    logic [63:0]       req_wdata;
    logic              resp_valid;
    logic [63:0]       resp_data;
    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [7:0]        mem_be;
    logic [71:0]       mem_wdata, mem_rdata;
    logic              err_valid, err_multi;
    logic [AW-1:0]     err_addr;

    logic              inj_en;
    logic [AW-1:0]     inj_addr;
    logic [71:0]       inj_mask;
    logic [71:0]       arr [DEPTH];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          o_busy, o_resp, o_nerr;
    logic        o_multi;
    logic [AW-1:0] o_eaddr;
    logic [63:0] o_rdata;

    ecc_mem_path #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .integ_mode(integ_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .err_valid(err_valid), .err_multi(err_multi), .err_addr(err_addr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model with an error-injection side channel
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) arr[k] <= '0;
            mem_rdata <= '0;
        end else if (inj_en) begin
            arr[inj_addr] <= arr[inj_addr] ^ inj_mask;
        end else if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) arr[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
                arr[mem_addr][71:64] <= mem_wdata[71:64];
            end else begin
                mem_rdata <= arr[mem_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mrg(input logic [63:0] old, input logic [63:0] nw, input logic [7:0] be);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
        return r;
    endfunction

    function automatic logic [63:0] pat(input int i, input int md);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(md) << 40);
    endfunction

    task automatic op(input bit wr, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic [7:0] be, input logic [1:0] md);
        bit fin;
        @(negedge clk);
        integ_mode = md; req_valid = 1'b1; req_write = wr;
        req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        #1 req_valid = 1'b0;
        o_busy = 0; o_resp = 0; o_nerr = 0; o_multi = 1'b0; o_eaddr = '0; o_rdata = '0;
        fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            if (resp_valid) begin o_resp++; o_rdata = resp_data; end
            if (err_valid) begin o_nerr++; o_multi = err_multi; o_eaddr = err_addr; end
            if (req_ready) fin = 1'b1;
            else o_busy++;
        end
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = m;
        @(posedge clk);
        #1 inj_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [71:0] clean, m, word;
        logic [63:0] d1, d2, exp;
        logic [AW-1:0] a;
        rst_n = 1'b0; integ_mode = 2'b00; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_be = '0; req_wdata = '0;
        inj_en = 1'b0; inj_addr = '0; inj_mask = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 72'(req_ready), 72'd1);
        chk(!resp_valid && !err_valid && !mem_en, "R1 idle outputs after reset",
            72'({resp_valid, err_valid, mem_en}), 72'd0);

        // Single and double flips of every stored bit in each checking mode
        for (int md = 1; md <= 3; md++) begin
            for (int i = 0; i < 72; i++) begin
                a  = AW'(i);
                d1 = pat(i, md);
                op(1'b1, a, d1, 8'hFF, 2'(md));
                chk(o_busy == 0, "R2 full write keeps ready", 72'(o_busy), 72'd0);
                clean = arr[a];
                chk(clean[63:0] == d1, "R2 data stored", clean, {8'h0, d1});
                op(1'b0, a, '0, 8'h00, 2'(md));
                chk(o_rdata == d1 && o_nerr == 0, "R2 clean readback", {8'(o_nerr), o_rdata}, {8'h0, d1});
                chk(o_busy == 1 && o_resp == 1, "R4 read latency", 72'(o_busy), 72'd1);

                m = 72'd1 << i;
                inject(a, m);
                op(1'b0, a, '0, 8'h00, 2'(md));
                word = clean ^ m;
                exp  = (md == 1) ? word[63:0] : d1;
                chk(o_rdata == exp, (md == 1) ? "R7 detect-only raw data" : "R5 single-bit corrected",
                    {8'h0, o_rdata}, {8'h0, exp});
                chk(o_nerr == 1 && !o_multi, "R5 single event", {o_multi, 8'(o_nerr)}, 72'd1);
                chk(o_eaddr == a, "R10 event address", 72'(o_eaddr), 72'(a));
                chk(o_busy == ((md == 3) ? 2 : 1), "R9 scrub busy cycles", 72'(o_busy), 72'((md == 3) ? 2 : 1));
                chk(arr[a] == ((md == 3) ? clean : word), (md == 3) ? "R9 word restored" : "R7 memory untouched",
                    arr[a], (md == 3) ? clean : word);

                op(1'b1, a, d1, 8'hFF, 2'(md));
                m = (72'd1 << i) | (72'd1 << ((i + 13) % 72));
                inject(a, m);
                op(1'b0, a, '0, 8'h00, 2'(md));
                word = clean ^ m;
                chk(o_rdata == word[63:0], "R6 double-bit raw data", {8'h0, o_rdata}, {8'h0, word[63:0]});
                chk(o_nerr == 1 && o_multi, "R6 multi event", {o_multi, 8'(o_nerr)}, {1'b1, 8'd1});
                chk(o_busy == 1 && arr[a] == word, "R6 no write-back", arr[a], word);
            end
        end

        // Mode 00: zero check byte, raw data, no events
        for (int i = 0; i < 72; i++) begin
            a  = AW'(i);
            d1 = pat(i, 0);
            op(1'b1, a, d1, 8'hFF, 2'b00);
            clean = arr[a];
            chk(clean == {8'h00, d1}, "R2 mode 00 zero check byte", clean, {8'h00, d1});
            inject(a, 72'd1 << i);
            op(1'b0, a, '0, 8'h00, 2'b00);
            word = clean ^ (72'd1 << i);
            chk(o_rdata == word[63:0] && o_nerr == 0, "R8 mode 00 raw and silent",
                {8'(o_nerr), o_rdata}, {8'h0, word[63:0]});
        end

        // Partial writes
        for (int md = 0; md <= 3; md++) begin
            a  = AW'(3 + md);
            d1 = pat(100, md);
            d2 = ~pat(200, md);
            op(1'b1, a, d1, 8'hFF, 2'(md));
            op(1'b1, a, d2, 8'h5A, 2'(md));
            chk(o_busy == ((md == 0) ? 0 : 2), "R3 partial write busy", 72'(o_busy), 72'((md == 0) ? 0 : 2));
            exp = mrg(d1, d2, 8'h5A);
            chk(arr[a][63:0] == exp, "R3 merged bytes in memory", {8'h0, arr[a][63:0]}, {8'h0, exp});
            op(1'b0, a, '0, 8'h00, 2'(md));
            chk(o_rdata == exp && o_nerr == 0, "R3 merged readback", {8'(o_nerr), o_rdata}, {8'h0, exp});
            if (md == 0) chk(arr[a][71:64] == 8'h00, "R3 mode 00 partial zero check byte", arr[a], {8'h00, exp});
        end

        // Partial write over a corrupted old word
        for (int md = 1; md <= 3; md++) begin
            a  = AW'(9 + md);
            d1 = pat(300, md);
            d2 = pat(400, md);
            op(1'b1, a, d1, 8'hFF, 2'(md));
            inject(a, 72'd1 << 5);
            op(1'b1, a, d2, 8'hF0, 2'(md));
            chk(o_nerr == 1 && !o_multi && o_eaddr == a, "R11 event on merge read",
                {o_multi, AW'(o_eaddr), 8'(o_nerr)}, {1'b0, a, 8'd1});
            chk(o_busy == 2, "R11 merge busy", 72'(o_busy), 72'd2);
            exp = (md == 1) ? mrg(d1 ^ 64'h20, d2, 8'hF0) : mrg(d1, d2, 8'hF0);
            op(1'b0, a, '0, 8'h00, 2'(md));
            chk(o_rdata == exp && o_nerr == 0, "R11 merged old bytes", {8'(o_nerr), o_rdata}, {8'h0, exp});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule